// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Unit

This block sits between an interrupt source controller and one processor. It holds the processor's current priority, a pending source number and that source's priority, plus an inter-processor-interrupt (IPI) priority. Lower numbers are more favoured. The source controller offers interrupts as a source number with a priority. The unit either installs the offer or bounces it back as a reject. An installed offer can displace a less favoured one that is already pending, and the displaced source is then rejected back to the controller. Whenever a source is pending, one level output to the processor is high.

The processor drives four register operations. Set-priority and set-IPI-priority take their value from the low byte of the write data. Accept returns the 32-bit pending word: current priority in bits 31:24 and source number in bits 23:0, where zero means nothing is pending. End-of-interrupt forwards a source number to the controller and reloads the current priority. Changing either priority can start a reject, an IPI installation, or a resend request to the source controller.

Operations have a small sequencer with four states. **IDLE** accepts an operation, or an offer when no operation is presented. **IPI_CHECK** evaluates the IPI after a set-IPI-priority write (IDLE→IPI_CHECK→IDLE). **RESEND_IPI** evaluates the IPI at the start of a resend (IDLE→RESEND_IPI). **RESEND_SEND** then pulses the resend request (RESEND_IPI→RESEND_SEND→IDLE). All other operations and offers complete in IDLE (IDLE→IDLE).

Top module: `intr_present_unit`

## Requirements
- R1: After reset the output is low, the current priority is 0 (everything masked), the IPI priority is 0xFF, and the pending source and pending priority are 0. An accept right after reset returns 0x00000000.
- R2: An offer whose priority is greater than or equal to the current priority is rejected. One cycle later `rej_valid` pulses with `rej_src` equal to the offered source, and nothing is installed.
- R3: An offer is also rejected when a source is already pending at a priority less than or equal to the offered one. The pending source is kept.
- R4: Otherwise the offer is installed. The output rises, `offer_taken` pulses, and any previously pending source is reported on `rej_src`.
- R5: Accept (op code 2) pulses `rd_valid` with `rd_data` = {current priority, pending source} and drops the output. Afterwards the current priority equals the pending priority and the source field is 0.
- R6: Set-priority (op code 0) with a value below the old one clears a pending source and rejects it, but only when the new value is less than or equal to that source's pending priority. Otherwise the pending source is kept.
- R7: Set-priority to a value not below the old one, with nothing pending, first runs the IPI check and then pulses `resend_req` once. A reject and a resend never share a cycle.
- R8: The IPI check installs source number 2 at the IPI priority when that priority is below the current priority and no source is pending at a priority less than or equal to it. Any pending source it displaces is rejected.
- R9: Set-IPI-priority (op code 1) with a value not below the current priority leaves the pending state and the output unchanged.
- R10: End-of-interrupt (op code 3) pulses `eoi_valid` with `eoi_src` = write data bits 23:0 and loads bits 31:24 as the current priority. It then requests a resend only if nothing is pending.
- R11: Operations take precedence. `offer_ready` is low whenever an operation is presented or the sequencer is not in IDLE, and an offer is not taken while `offer_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Source controller offers an interrupt |
| offer_ready | output | 1 | Offer is taken this cycle if valid |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| offer_taken | output | 1 | Pulse: last offer was installed |
| op_valid | input | 1 | Processor register operation presented |
| op_ready | output | 1 | Operation is taken this cycle if valid |
| op_kind | input | 2 | 0 set priority, 1 set IPI priority, 2 accept, 3 end-of-interrupt |
| op_wdata | input | 32 | Operation write data |
| rd_valid | output | 1 | Pulse: accept result valid |
| rd_data | output | 32 | Pending word returned by accept |
| int_out | output | 1 | Level interrupt to the processor |
| rej_valid | output | 1 | Pulse: a source is rejected |
| rej_src | output | 24 | Rejected source number |
| resend_req | output | 1 | Pulse: ask the source controller to resend |
| eoi_valid | output | 1 | Pulse: end-of-interrupt forwarded |
| eoi_src | output | 24 | Source number of the end-of-interrupt |

## Verification
Accept data, rejects, the taken pulse, end-of-interrupt forwarding and output changes from offers, accepts and priority lowering are all due one cycle after the edge that takes the request. An IPI installed after a set-IPI-priority write or at the start of a resend appears two cycles after that edge. The resend pulse appears three cycles after it. The bench drives inputs on falling edges and counts the one-cycle pulses on falling edges. After each request it waits three cycles, so all results are settled before it compares levels or pulse-count deltas.

// File: rtl/ipu_pkg.sv
package ipu_pkg;

    typedef enum logic [1:0] {
        OP_SET_CPPR = 2'd0,
        OP_SET_IPI  = 2'd1,
        OP_ACCEPT   = 2'd2,
        OP_EOI      = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_IPI_CHECK  = 2'd1,
        ST_RESEND_IPI = 2'd2,
        ST_RESEND_SEND = 2'd3
    } ipu_state_e;

endpackage

// File: rtl/ipu_offer_eval.sv
module ipu_offer_eval #(
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 24
) (
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [SRC_W-1:0]  pend_src,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [PRIO_W-1:0] cand_prio,
    output logic              take,
    output logic              displace
);
    logic busy;
    logic beaten;
    logic masked;

    always_comb begin
        busy     = (pend_src != '0);
        masked   = (cand_prio >= cur_prio);
        beaten   = busy && (pend_prio <= cand_prio);
        take     = !masked && !beaten;
        displace = take && busy;
    end
endmodule

// File: rtl/ipu_fsm.sv
module ipu_fsm
    import ipu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_fire,
    input  op_kind_e   op_kind,
    input  logic       go_resend,
    output ipu_state_e state
);
    ipu_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (op_fire) begin
                    if (op_kind == OP_SET_IPI) begin
                        state_nx = ST_IPI_CHECK;
                    end else if (go_resend) begin
                        state_nx = ST_RESEND_IPI;
                    end
                end
            end
            ST_IPI_CHECK:   state_nx = ST_IDLE;
            ST_RESEND_IPI:  state_nx = ST_RESEND_SEND;
            ST_RESEND_SEND: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    p_seq_leaves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESEND_IPI) |=> (state == ST_RESEND_SEND));
endmodule

// File: rtl/intr_present_unit.sv
module intr_present_unit
    import ipu_pkg::*;
#(
    parameter int PRIO_W  = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    offer_valid,
    output logic                    offer_ready,
    input  logic [SRC_W-1:0]        offer_src,
    input  logic [PRIO_W-1:0]       offer_prio,
    output logic                    offer_taken,
    input  logic                    op_valid,
    output logic                    op_ready,
    input  logic [1:0]              op_kind,
    input  logic [PRIO_W+SRC_W-1:0] op_wdata,
    output logic                    rd_valid,
    output logic [PRIO_W+SRC_W-1:0] rd_data,
    output logic                    int_out,
    output logic                    rej_valid,
    output logic [SRC_W-1:0]        rej_src,
    output logic                    resend_req,
    output logic                    eoi_valid,
    output logic [SRC_W-1:0]        eoi_src
);
    localparam int WORD_W = PRIO_W + SRC_W;
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
    localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

    ipu_state_e        state;
    op_kind_e          kind;
    logic [PRIO_W-1:0] cur_prio;
    logic [PRIO_W-1:0] ipi_prio;
    logic [PRIO_W-1:0] pend_prio;
    logic [SRC_W-1:0]  pend_src;

    logic              op_fire;
    logic              offer_fire;
    logic              go_resend;
    logic [PRIO_W-1:0] wr_low;
    logic [PRIO_W-1:0] wr_top;
    logic [SRC_W-1:0]  wr_src;
    logic [PRIO_W-1:0] cand_prio;
    logic              take;
    logic              displace;

    always_comb begin
        kind        = op_kind_e'(op_kind);
        op_ready    = (state == ST_IDLE);
        offer_ready = (state == ST_IDLE) && !op_valid;
        op_fire     = op_valid && op_ready;
        offer_fire  = offer_valid && offer_ready;
        wr_low      = op_wdata[PRIO_W-1:0];
        wr_top      = op_wdata[WORD_W-1:SRC_W];
        wr_src      = op_wdata[SRC_W-1:0];
        cand_prio   = (state == ST_IDLE) ? offer_prio : ipi_prio;
        unique case (kind)
            OP_SET_CPPR: go_resend = !(wr_low < cur_prio) && (pend_src == '0);
            OP_EOI:      go_resend = (pend_src == '0);
            default:     go_resend = 1'b0;
        endcase
    end

    ipu_offer_eval #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_eval (
        .cur_prio (cur_prio),
        .pend_src (pend_src),
        .pend_prio(pend_prio),
        .cand_prio(cand_prio),
        .take     (take),
        .displace (displace)
    );

    ipu_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_fire  (op_fire),
        .op_kind  (kind),
        .go_resend(go_resend),
        .state    (state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_prio    <= '0;
            ipi_prio    <= PRIO_NONE;
            pend_prio   <= '0;
            pend_src    <= '0;
            int_out     <= 1'b0;
            rej_valid   <= 1'b0;
            rej_src     <= '0;
            resend_req  <= 1'b0;
            eoi_valid   <= 1'b0;
            eoi_src     <= '0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            offer_taken <= 1'b0;
        end else begin
            rej_valid   <= 1'b0;
            resend_req  <= 1'b0;
            eoi_valid   <= 1'b0;
            rd_valid    <= 1'b0;
            offer_taken <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (op_fire) begin
                        unique case (kind)
                            OP_SET_CPPR: begin
                                cur_prio <= wr_low;
                                if ((wr_low < cur_prio) && (pend_src != '0)
                                    && (wr_low <= pend_prio)) begin
                                    pend_src  <= '0;
                                    int_out   <= 1'b0;
                                    rej_valid <= 1'b1;
                                    rej_src   <= pend_src;
                                end
                            end
                            OP_SET_IPI: begin
                                ipi_prio <= wr_low;
                            end
                            OP_ACCEPT: begin
                                rd_valid <= 1'b1;
                                rd_data  <= {cur_prio, pend_src};
                                cur_prio <= pend_prio;
                                pend_src <= '0;
                                int_out  <= 1'b0;
                            end
                            OP_EOI: begin
                                eoi_valid <= 1'b1;
                                eoi_src   <= wr_src;
                                cur_prio  <= wr_top;
                            end
                        endcase
                    end else if (offer_fire) begin
                        if (take) begin
                            if (displace) begin
                                rej_valid <= 1'b1;
                                rej_src   <= pend_src;
                            end
                            pend_src    <= offer_src;
                            pend_prio   <= offer_prio;
                            int_out     <= 1'b1;
                            offer_taken <= 1'b1;
                        end else begin
                            rej_valid <= 1'b1;
                            rej_src   <= offer_src;
                        end
                    end
                end
                ST_IPI_CHECK, ST_RESEND_IPI: begin
                    if (take) begin
                        if (displace) begin
                            rej_valid <= 1'b1;
                            rej_src   <= pend_src;
                        end
                        pend_src  <= IPI_NUM;
                        pend_prio <= ipi_prio;
                        int_out   <= 1'b1;
                    end
                end
                ST_RESEND_SEND: begin
                    resend_req <= 1'b1;
                end
            endcase
        end
    end

    // Output level agrees with the pending source field (R4, R5).
    p_out_tracks_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int_out == (pend_src != '0));

    p_reject_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_fire && (offer_prio >= cur_prio))
        |=> (rej_valid && (rej_src == $past(offer_src)) && !offer_taken));

    p_taken_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
        offer_fire |=> (offer_taken == (pend_src == $past(offer_src)))
                       && (!offer_taken || int_out));

    p_accept_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && (kind == OP_ACCEPT)) |=> (rd_valid && !int_out));

    p_eoi_forward_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && (kind == OP_EOI))
        |=> (eoi_valid && (eoi_src == $past(wr_src)) && (cur_prio == $past(wr_top))));

    p_rej_resend_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rej_valid && resend_req));

    p_offer_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !offer_ready);
endmodule

// File: tb/intr_present_unit_tb.sv
`timescale 1ns/1ps
module intr_present_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offer_valid = 1'b0;
    logic        offer_ready;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic        offer_taken;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [1:0]  op_kind = '0;
    logic [31:0] op_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        int_out;
    logic        rej_valid;
    logic [23:0] rej_src;
    logic        resend_req;
    logic        eoi_valid;
    logic [23:0] eoi_src;

    int n_checks = 0;
    int n_err = 0;
    int rej_cnt = 0, resend_cnt = 0, eoi_cnt = 0, taken_cnt = 0;
    logic [23:0] last_rej = '0, last_eoi = '0;
    logic [31:0] last_rd = '1;
    bit done = 0;

    always #4 clk = ~clk;

    intr_present_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .offer_valid(offer_valid), .offer_ready(offer_ready),
        .offer_src(offer_src), .offer_prio(offer_prio), .offer_taken(offer_taken),
        .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind), .op_wdata(op_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .int_out(int_out),
        .rej_valid(rej_valid), .rej_src(rej_src), .resend_req(resend_req),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rej_valid)   begin rej_cnt++; last_rej = rej_src; end
            if (resend_req)  resend_cnt++;
            if (eoi_valid)   begin eoi_cnt++; last_eoi = eoi_src; end
            if (offer_taken) taken_cnt++;
            if (rd_valid)    last_rd = rd_data;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] k, input logic [31:0] d);
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; op_wdata = d;
        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_offer(input logic [23:0] s, input logic [7:0] p);
        @(negedge clk);
        offer_valid = 1'b1; offer_src = s; offer_prio = p;
        @(negedge clk);
        offer_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "int_out after reset", 32'(int_out), 0);
        check("R1", "op_ready after reset", 32'(op_ready), 1);
        do_op(2'd2, 0);
        check("R1", "accept after reset", last_rd, 32'h0000_0000);
        do_offer(24'h5, 8'h03);
        check("R2", "offer masked by prio 0", last_rej, 24'h5);
        check("R2", "masked offer not taken", 32'(taken_cnt), 0);
    endtask

    task automatic t_offers;
        int r0;
        r0 = resend_cnt;
        do_op(2'd0, 32'h80);
        check("R7", "resend after raise", 32'(resend_cnt - r0), 1);
        do_offer(24'h10, 8'h40);
        check("R4", "first offer raises output", 32'(int_out), 1);
        r0 = rej_cnt;
        do_offer(24'h11, 8'h40);
        check("R3", "equal prio offer rejected", last_rej, 24'h11);
        do_offer(24'h12, 8'h90);
        check("R2", "offer above cur prio rejected", last_rej, 24'h12);
        do_offer(24'h13, 8'h20);
        check("R4", "displaced source rejected", last_rej, 24'h10);
        check("R4", "reject count", 32'(rej_cnt - r0), 3);
        do_op(2'd2, 0);
        check("R5", "accept word", last_rd, 32'h8000_0013);
        check("R5", "output low after accept", 32'(int_out), 0);
        do_op(2'd2, 0);
        check("R5", "cur prio took pending prio", last_rd, 32'h2000_0000);
    endtask

    task automatic t_eoi_idle;
        int r0;
        r0 = resend_cnt;
        do_op(2'd3, 32'h8000_0013);
        check("R10", "eoi source", last_eoi, 24'h13);
        check("R10", "resend after eoi idle", 32'(resend_cnt - r0), 1);
        do_op(2'd2, 0);
        check("R10", "cur prio from eoi", last_rd, 32'h8000_0000);
    endtask

    task automatic t_lower;
        int r0;
        do_op(2'd0, 32'hF0);
        do_offer(24'h30, 8'h50);
        r0 = rej_cnt;
        do_op(2'd0, 32'h60);
        check("R6", "lower above pend keeps output", 32'(int_out), 1);
        check("R6", "lower above pend no reject", 32'(rej_cnt - r0), 0);
        do_op(2'd0, 32'h50);
        check("R6", "lower to pend drops output", 32'(int_out), 0);
        check("R6", "lower to pend rejects", last_rej, 24'h30);
        do_op(2'd2, 0);
        check("R6", "source cleared", last_rd, 32'h5000_0000);
    endtask

    task automatic t_ipi;
        int r0;
        do_op(2'd1, 32'h60);
        check("R9", "ipi at/above cur ignored", 32'(int_out), 0);
        r0 = resend_cnt;
        do_op(2'd0, 32'hFF);
        check("R8", "ipi installed during resend", 32'(int_out), 1);
        check("R7", "resend after ipi check", 32'(resend_cnt - r0), 1);
        do_op(2'd2, 0);
        check("R8", "ipi accept word", last_rd, 32'hFF00_0002);
        do_op(2'd1, 32'hFF);
        do_op(2'd0, 32'hF0);
        do_offer(24'h40, 8'h70);
        r0 = rej_cnt;
        do_op(2'd1, 32'h70);
        check("R8", "ipi beaten by equal pending", 32'(rej_cnt - r0), 0);
        do_op(2'd1, 32'h30);
        check("R8", "ipi displaces pending", last_rej, 24'h40);
        do_op(2'd2, 0);
        check("R8", "ipi source after displace", last_rd, 32'hF000_0002);
    endtask

    task automatic t_eoi_busy;
        int r0;
        do_offer(24'h55, 8'h10);
        r0 = resend_cnt;
        do_op(2'd3, 32'h4000_0055);
        check("R10", "no resend while pending", 32'(resend_cnt - r0), 0);
        do_op(2'd2, 0);
        check("R10", "eoi keeps pending", last_rd, 32'h4000_0055);
    endtask

    task automatic t_precedence;
        int t0, j0;
        t0 = taken_cnt; j0 = rej_cnt;
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'd1; op_wdata = 32'hFF;
        offer_valid = 1'b1; offer_src = 24'h77; offer_prio = 8'h05;
        #1;
        check("R11", "offer_ready low with op", 32'(offer_ready), 0);
        @(negedge clk);
        op_valid = 1'b0;
        check("R11", "offer_ready low while busy", 32'(offer_ready), 0);
        offer_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", "blocked offer not taken", 32'(taken_cnt - t0), 0);
        check("R11", "blocked offer not rejected", 32'(rej_cnt - j0), 0);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_offers;
        t_eoi_idle;
        t_lower;
        t_ipi;
        t_eoi_busy;
        t_precedence;
        done = 1;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL R11 watchdog: actual %h expected %h", 0, 1);
            finish_run;
        end
    end
endmodule